// File: doc/BRIEF.md
# Thread-Local Pointer Register Unit

This block is a small slice of a processor's system-control register space. It holds one software-owned thread pointer and one hardware-read enable mask. Privileged code reads and writes both through an addressed register port (register number plus select). User code reaches the thread pointer only through a read-hardware-register request with index 29. That request succeeds when the core is privileged or when mask bit 29 is set. Otherwise it raises a reserved-instruction exception.

The whole feature depends on a static presence input. When that input is low, the pointer register behaves as absent: reads return zero, writes are dropped, and mask bit 29 cannot be set. All responses come from a four-state response machine with named states:

- `RS_IDLE`: no response this cycle.
- `RS_DATA`: `rd_valid` is high with data.
- `RS_TRAP`: `ri_exc` is high.
- `RS_PASS`: `hw_unhandled` is high, so logic outside the block can answer a hardware index it does not own.

Every cycle the machine moves from any state to the state chosen by that cycle's request. With no request it returns to `RS_IDLE`. Each response therefore lasts exactly one cycle and appears one cycle after the request.

Top module: `tlr_unit`

## Requirements
- R1: After reset the thread pointer and the enable mask are zero, and `rd_valid`, `ri_exc`, `hw_unhandled` and `rd_data` are all zero.
- R2: With `feat_present`=1, a write to register 4 select 2 stores the full value unchanged. A read of register 4 select 2 returns it with `rd_valid`=1.
- R3: With `feat_present`=0, a read of register 4 select 2 returns zero with `rd_valid`=1, and a write to it is ignored.
- R4: The enable mask lives at register 7 select 0. A write keeps bits 3:0, and keeps bit 29 only when `feat_present`=1. Every other bit reads back as zero.
- R5: A hardware read with index 29 while `priv_mode`=1 returns the thread pointer, whatever the mask holds.
- R6: A hardware read with index 29 while `priv_mode`=0 and mask bit 29 = 1 returns the thread pointer.
- R7: A hardware read with index 29 while `priv_mode`=0 and mask bit 29 = 0 gives `ri_exc`=1 and `rd_valid`=0, with `rd_data` zero.
- R8: A hardware read with any index other than 29 gives `hw_unhandled`=1, with `rd_valid`=0, `ri_exc`=0 and `rd_data` zero.
- R9: Timing and ordering:
  - Every response is registered: it appears in the cycle after the request and lasts one cycle.
  - A cycle with no request gives no response.
  - A request sees register writes made in earlier cycles, but not a write in the same cycle.
- R10: A privileged read with `cp_rd_is32`=1 returns the low 32 bits of the register, sign-extended to XLEN.
- R11: A hardware read and a privileged read in the same cycle: the hardware read is answered and the privileged read is dropped. A privileged read of any address other than the two registers gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| feat_present | input | 1 | Static: thread pointer register exists |
| priv_mode | input | 1 | Core is in privileged mode |
| cp_wr_en | input | 1 | Privileged register write strobe |
| cp_wr_num | input | 5 | Write register number |
| cp_wr_sel | input | 3 | Write select |
| cp_wr_data | input | XLEN | Write data |
| cp_rd_en | input | 1 | Privileged register read strobe |
| cp_rd_num | input | 5 | Read register number |
| cp_rd_sel | input | 3 | Read select |
| cp_rd_is32 | input | 1 | 32-bit read, sign-extended |
| hw_rd_en | input | 1 | Read-hardware-register request |
| hw_rd_idx | input | 5 | Hardware register index |
| rd_data | output | XLEN | Response data, zero unless rd_valid |
| rd_valid | output | 1 | Data response strobe |
| ri_exc | output | 1 | Reserved-instruction exception strobe |
| hw_unhandled | output | 1 | Hardware index not owned by this block |

## Verification
The bench targets four corner cases:

- **Write and request in the same cycle.** A write to the mask and a user request in the same cycle must use the old mask, and the request in the next cycle must use the new one. A design that bypassed the write, or that delayed it by an extra stage, would grant or trap on the wrong cycle.
- **Feature absent.** The bench runs a second reset phase with the presence input low. A design that left mask bit 29 writable there, or stored the pointer anyway, would return data where a trap or a zero is due.
- **32-bit reads.** A word with bit 31 set must come back with the upper half all ones.
- **Simultaneous requests.** When both read kinds arrive together, the hardware read must be answered and the privileged read dropped. A wrong priority would return the privileged data instead.

// File: rtl/tlr_pkg.sv
package tlr_pkg;
    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_DATA = 2'd1,
        RS_TRAP = 2'd2,
        RS_PASS = 2'd3
    } rsp_state_e;

    localparam int unsigned NUM_W       = 5;
    localparam int unsigned SEL_W       = 3;
    localparam logic [4:0]  TP_NUM      = 5'd4;
    localparam logic [2:0]  TP_SEL      = 3'd2;
    localparam logic [4:0]  EN_NUM      = 5'd7;
    localparam logic [2:0]  EN_SEL      = 3'd0;
    localparam logic [4:0]  TP_HW_IDX   = 5'd29;
    localparam int unsigned EN_TP_BIT   = 29;
    localparam int unsigned EN_LOW_BITS = 4;
endpackage

// File: rtl/tlr_regs.sv
module tlr_regs #(
    parameter int unsigned XLEN = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         feat_present,
    input  logic                         wr_en,
    input  logic [tlr_pkg::NUM_W-1:0]    wr_num,
    input  logic [tlr_pkg::SEL_W-1:0]    wr_sel,
    input  logic [XLEN-1:0]              wr_data,
    output logic [XLEN-1:0]              tp_q,
    output logic [XLEN-1:0]              mask_q
);
    import tlr_pkg::*;

    logic            hit_tp;
    logic            hit_en;
    logic [XLEN-1:0] keep;

    assign hit_tp = wr_en && (wr_num == TP_NUM) && (wr_sel == TP_SEL);
    assign hit_en = wr_en && (wr_num == EN_NUM) && (wr_sel == EN_SEL);

    always_comb begin
        keep                    = '0;
        keep[EN_LOW_BITS-1:0]   = '1;
        keep[EN_TP_BIT]         = feat_present;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tp_q   <= '0;
            mask_q <= '0;
        end else begin
            if (hit_tp && feat_present) tp_q <= wr_data;
            if (hit_en) mask_q <= wr_data & keep;
        end
    end

    // R3: with the feature absent the pointer never leaves zero
    p_tp_absent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !feat_present |-> tp_q == '0);

    // R2: pointer only changes on an addressed write
    p_tp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_tp |=> $stable(tp_q));

    // R4: bit 29 of the mask cannot be set when the feature is absent
    p_mask_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !feat_present |-> !mask_q[EN_TP_BIT]);
endmodule

// File: rtl/tlr_decide.sv
module tlr_decide #(
    parameter int unsigned XLEN = 64
) (
    input  logic                         feat_present,
    input  logic                         priv_mode,
    input  logic                         hw_rd_en,
    input  logic [tlr_pkg::NUM_W-1:0]    hw_rd_idx,
    input  logic                         cp_rd_en,
    input  logic [tlr_pkg::NUM_W-1:0]    cp_rd_num,
    input  logic [tlr_pkg::SEL_W-1:0]    cp_rd_sel,
    input  logic                         cp_rd_is32,
    input  logic [XLEN-1:0]              tp_q,
    input  logic [XLEN-1:0]              mask_q,
    output tlr_pkg::rsp_state_e          nxt_state,
    output logic [XLEN-1:0]              nxt_data
);
    import tlr_pkg::*;

    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] ext;
    logic            cp_hit;

    generate
        if (XLEN > 32) begin : g_sext
            assign ext = {{(XLEN-32){raw[31]}}, raw[31:0]};
        end else begin : g_nosext
            assign ext = raw;
        end
    endgenerate

    always_comb begin
        nxt_state = RS_IDLE;
        raw       = '0;
        cp_hit    = 1'b0;
        if (hw_rd_en) begin
            if (hw_rd_idx == TP_HW_IDX) begin
                if (priv_mode || mask_q[EN_TP_BIT]) begin
                    nxt_state = RS_DATA;
                    raw       = tp_q;
                end else begin
                    nxt_state = RS_TRAP;
                end
            end else begin
                nxt_state = RS_PASS;
            end
        end else if (cp_rd_en) begin
            if (cp_rd_num == TP_NUM && cp_rd_sel == TP_SEL) begin
                nxt_state = RS_DATA;
                raw       = feat_present ? tp_q : '0;
                cp_hit    = 1'b1;
            end else if (cp_rd_num == EN_NUM && cp_rd_sel == EN_SEL) begin
                nxt_state = RS_DATA;
                raw       = mask_q;
                cp_hit    = 1'b1;
            end
        end
        nxt_data = (cp_hit && cp_rd_is32) ? ext : raw;
    end
endmodule

// File: rtl/tlr_unit.sv
module tlr_unit #(
    parameter int unsigned XLEN = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         feat_present,
    input  logic                         priv_mode,
    input  logic                         cp_wr_en,
    input  logic [4:0]                   cp_wr_num,
    input  logic [2:0]                   cp_wr_sel,
    input  logic [XLEN-1:0]              cp_wr_data,
    input  logic                         cp_rd_en,
    input  logic [4:0]                   cp_rd_num,
    input  logic [2:0]                   cp_rd_sel,
    input  logic                         cp_rd_is32,
    input  logic                         hw_rd_en,
    input  logic [4:0]                   hw_rd_idx,
    output logic [XLEN-1:0]              rd_data,
    output logic                         rd_valid,
    output logic                         ri_exc,
    output logic                         hw_unhandled
);
    import tlr_pkg::*;

    logic [XLEN-1:0] tp_q;
    logic [XLEN-1:0] mask_q;
    logic [XLEN-1:0] nxt_data;
    logic [XLEN-1:0] data_q;
    rsp_state_e      nxt_state;
    rsp_state_e      state_q;

    tlr_regs #(.XLEN(XLEN)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .feat_present (feat_present),
        .wr_en        (cp_wr_en),
        .wr_num       (cp_wr_num),
        .wr_sel       (cp_wr_sel),
        .wr_data      (cp_wr_data),
        .tp_q         (tp_q),
        .mask_q       (mask_q)
    );

    tlr_decide #(.XLEN(XLEN)) u_decide (
        .feat_present (feat_present),
        .priv_mode    (priv_mode),
        .hw_rd_en     (hw_rd_en),
        .hw_rd_idx    (hw_rd_idx),
        .cp_rd_en     (cp_rd_en),
        .cp_rd_num    (cp_rd_num),
        .cp_rd_sel    (cp_rd_sel),
        .cp_rd_is32   (cp_rd_is32),
        .tp_q         (tp_q),
        .mask_q       (mask_q),
        .nxt_state    (nxt_state),
        .nxt_data     (nxt_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= nxt_state;
            data_q  <= nxt_data;
        end
    end

    // output decode
    always_comb begin
        rd_data      = '0;
        rd_valid     = 1'b0;
        ri_exc       = 1'b0;
        hw_unhandled = 1'b0;
        unique case (state_q)
            RS_IDLE: ;
            RS_DATA: begin
                rd_valid = 1'b1;
                rd_data  = data_q;
            end
            RS_TRAP: ri_exc = 1'b1;
            RS_PASS: hw_unhandled = 1'b1;
            default: ;
        endcase
    end

    p_priv_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_rd_en && hw_rd_idx == TP_HW_IDX && priv_mode)
        |=> (rd_valid && rd_data == $past(tp_q)));

    p_user_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_rd_en && hw_rd_idx == TP_HW_IDX && !priv_mode && mask_q[EN_TP_BIT])
        |=> (rd_valid && rd_data == $past(tp_q)));

    p_user_deny_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_rd_en && hw_rd_idx == TP_HW_IDX && !priv_mode && !mask_q[EN_TP_BIT])
        |=> (ri_exc && !rd_valid && rd_data == '0));

    p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_rd_en && hw_rd_idx != TP_HW_IDX) |=> (hw_unhandled && !ri_exc && !rd_valid));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_rd_en && !cp_rd_en) |=> (!rd_valid && !ri_exc && !hw_unhandled));

    p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, ri_exc, hw_unhandled}));
endmodule

// File: tb/tb_tlr_unit.sv
module tb_tlr_unit;
    localparam int unsigned XLEN  = 64;
    localparam int          CLK_P = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            feat_present;
    logic            priv_mode;
    logic            cp_wr_en;
    logic [4:0]      cp_wr_num;
    logic [2:0]      cp_wr_sel;
    logic [XLEN-1:0] cp_wr_data;
    logic            cp_rd_en;
    logic [4:0]      cp_rd_num;
    logic [2:0]      cp_rd_sel;
    logic            cp_rd_is32;
    logic            hw_rd_en;
    logic [4:0]      hw_rd_idx;
    logic [XLEN-1:0] rd_data;
    logic            rd_valid;
    logic            ri_exc;
    logic            hw_unhandled;

    int n_tests = 0;
    int n_fail  = 0;

    logic [XLEN-1:0] m_tp;
    logic [XLEN-1:0] m_mask;

    always #(CLK_P/2) clk = ~clk;

    tlr_unit #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .feat_present(feat_present), .priv_mode(priv_mode),
        .cp_wr_en(cp_wr_en), .cp_wr_num(cp_wr_num), .cp_wr_sel(cp_wr_sel),
        .cp_wr_data(cp_wr_data), .cp_rd_en(cp_rd_en), .cp_rd_num(cp_rd_num),
        .cp_rd_sel(cp_rd_sel), .cp_rd_is32(cp_rd_is32), .hw_rd_en(hw_rd_en),
        .hw_rd_idx(hw_rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
        .ri_exc(ri_exc), .hw_unhandled(hw_unhandled)
    );

    function automatic logic [XLEN-1:0] f_mask(input logic [XLEN-1:0] d, input logic f);
        logic [XLEN-1:0] r;
        r = '0;
        r[3:0] = d[3:0];
        if (f) r[29] = d[29];
        return r;
    endfunction

    function automatic logic [XLEN-1:0] f_sext(input logic [XLEN-1:0] d);
        return {{(XLEN-32){d[31]}}, d[31:0]};
    endfunction

    task automatic idle_inputs();
        cp_wr_en = 0; cp_wr_num = 0; cp_wr_sel = 0; cp_wr_data = '0;
        cp_rd_en = 0; cp_rd_num = 0; cp_rd_sel = 0; cp_rd_is32 = 0;
        hw_rd_en = 0; hw_rd_idx = 0; priv_mode = 0;
    endtask

    task automatic check_out(input string tag, input logic ev, input logic ex,
                             input logic ep, input logic [XLEN-1:0] ed);
        n_tests++;
        if (rd_valid !== ev || ri_exc !== ex || hw_unhandled !== ep || rd_data !== ed) begin
            n_fail++;
            $display("FAIL %s: got v=%0b x=%0b p=%0b d=%h, expected v=%0b x=%0b p=%0b d=%h",
                     tag, rd_valid, ri_exc, hw_unhandled, rd_data, ev, ex, ep, ed);
        end
    endtask

    task automatic do_reset(input logic f);
        @(negedge clk);
        rst_n = 0;
        feat_present = f;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_tp = '0;
        m_mask = '0;
        check_out("R1 reset", 0, 0, 0, '0);
    endtask

    // one cycle: drive at negedge, response checked at following negedge
    task automatic cyc(input logic we, input logic [4:0] wn, input logic [2:0] ws,
                       input logic [XLEN-1:0] wd, input logic re, input logic [4:0] rn,
                       input logic [2:0] rs, input logic r32, input logic he,
                       input logic [4:0] hi, input logic pm);
        logic ev, ex, ep;
        logic [XLEN-1:0] ed;
        string tag;
        ev = 0; ex = 0; ep = 0; ed = '0; tag = "R9";
        if (he) begin
            if (hi == 5'd29) begin
                if (pm) begin ev = 1; ed = m_tp; tag = "R5"; end
                else if (m_mask[29]) begin ev = 1; ed = m_tp; tag = "R6"; end
                else begin ex = 1; tag = "R7"; end
            end else begin
                ep = 1; tag = "R8";
            end
            if (re) tag = {tag, " R11"};
        end else if (re) begin
            if (rn == 5'd4 && rs == 3'd2) begin
                ev = 1; ed = m_tp; tag = feat_present ? "R2" : "R3";
            end else if (rn == 5'd7 && rs == 3'd0) begin
                ev = 1; ed = m_mask; tag = "R4";
            end else begin
                tag = "R11";
            end
            if (ev && r32) begin ed = f_sext(ed); tag = {tag, " R10"}; end
        end
        cp_wr_en = we; cp_wr_num = wn; cp_wr_sel = ws; cp_wr_data = wd;
        cp_rd_en = re; cp_rd_num = rn; cp_rd_sel = rs; cp_rd_is32 = r32;
        hw_rd_en = he; hw_rd_idx = hi; priv_mode = pm;
        @(posedge clk);
        @(negedge clk);
        check_out(tag, ev, ex, ep, ed);
        if (we) begin
            if (wn == 5'd4 && ws == 3'd2 && feat_present) m_tp = wd;
            if (wn == 5'd7 && ws == 3'd0) m_mask = f_mask(wd, feat_present);
        end
        idle_inputs();
    endtask

    task automatic wr(input logic [4:0] n, input logic [2:0] s, input logic [XLEN-1:0] d);
        cyc(1, n, s, d, 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic rnd_phase(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            logic [4:0] wn, rn;
            logic [2:0] ws, rs;
            int k;
            k  = $urandom_range(0, 3);
            wn = (k == 0) ? 5'd4 : (k == 1) ? 5'd7 : 5'($urandom);
            ws = (k == 0) ? 3'd2 : (k == 1) ? 3'd0 : 3'($urandom);
            k  = $urandom_range(0, 3);
            rn = (k == 0) ? 5'd4 : (k == 1) ? 5'd7 : 5'($urandom);
            rs = (k == 0) ? 3'd2 : (k == 1) ? 3'd0 : 3'($urandom);
            cyc(($urandom_range(0, 2) == 0), wn, ws, {$urandom, $urandom},
                ($urandom_range(0, 2) == 0), rn, rs, 1'($urandom),
                ($urandom_range(0, 2) == 0),
                ($urandom_range(0, 1) == 0) ? 5'd29 : 5'($urandom), 1'($urandom));
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        rst_n = 0;
        feat_present = 1;
        idle_inputs();

        // ---- feature present ----
        do_reset(1);
        cyc(0, 0, 0, '0, 1, 5'd4, 3'd2, 0, 0, 0, 1);               // R1 pointer zero
        cyc(0, 0, 0, '0, 1, 5'd7, 3'd0, 0, 0, 0, 1);               // R1 mask zero
        wr(5'd4, 3'd2, 64'h8000_0001_DEAD_BEEF);
        cyc(0, 0, 0, '0, 1, 5'd4, 3'd2, 0, 0, 0, 1);               // R2
        cyc(0, 0, 0, '0, 1, 5'd4, 3'd2, 1, 0, 0, 1);               // R10 negative word
        wr(5'd7, 3'd0, '1);
        cyc(0, 0, 0, '0, 1, 5'd7, 3'd0, 0, 0, 0, 1);               // R4 expect 2000000F
        cyc(0, 0, 0, '0, 0, 0, 0, 0, 1, 5'd29, 0);                 // R6 user granted
        wr(5'd7, 3'd0, '0);
        cyc(0, 0, 0, '0, 0, 0, 0, 0, 1, 5'd29, 0);                 // R7/R9 next cycle sees cleared
        cyc(1, 5'd7, 3'd0, 64'h2000_0000, 0, 0, 0, 0, 1, 5'd29, 0);// R9 same cycle: old mask
        cyc(0, 0, 0, '0, 0, 0, 0, 0, 1, 5'd29, 0);                 // R6 new mask visible
        wr(5'd7, 3'd0, '0);
        cyc(0, 0, 0, '0, 0, 0, 0, 0, 1, 5'd29, 1);                 // R5 privileged
        cyc(0, 0, 0, '0, 0, 0, 0, 0, 1, 5'd3, 0);                  // R8
        cyc(0, 0, 0, '0, 1, 5'd4, 3'd2, 0, 1, 5'd2, 1);            // R11 hw wins
        cyc(0, 0, 0, '0, 1, 5'd5, 3'd0, 0, 0, 0, 1);               // R11 foreign address
        cyc(0, 0, 0, '0, 0, 0, 0, 0, 0, 0, 0);                     // R9 idle
        rnd_phase(400);

        // ---- feature absent ----
        do_reset(0);
        wr(5'd4, 3'd2, 64'h1234_5678_9ABC_DEF0);
        cyc(0, 0, 0, '0, 1, 5'd4, 3'd2, 0, 0, 0, 1);               // R3 read zero
        cyc(0, 0, 0, '0, 0, 0, 0, 0, 1, 5'd29, 1);                 // R3 write ignored
        wr(5'd7, 3'd0, '1);
        cyc(0, 0, 0, '0, 1, 5'd7, 3'd0, 0, 0, 0, 1);               // R4 expect F
        cyc(0, 0, 0, '0, 0, 0, 0, 0, 1, 5'd29, 0);                 // R4/R7 trap
        rnd_phase(400);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule